// File: doc/BRIEF.md
# Data Channel Transfer Sequencer

This block is the processor-side engine that carries out one data-channel transfer for a peripheral. A device raises two request lines: a channel request and a single-cycle request. The sequencer reads the pair as a two-bit code. From that code, and from a few qualifying device lines, it picks one kind of job. It can store a device word at an absolute address or read a word out to the device. It can run a full multi-cycle block transfer. It can also increment one memory word, or add a device word to one memory word.

A multi-cycle transfer is driven by two control words held in memory. The word count sits at the address the device supplies, and the current address sits at the next word. The word count holds the negative of the number of words left, in two's complement. The sequencer reads it, adds one, writes it back, and raises a one-cycle overflow pulse when the new count is zero. That pulse tells the device that the word now moving is the last one. The sequencer then reads the current address and normally advances it by one and writes it back. A device-driven inhibit line keeps it unchanged. The single data word then moves at the resulting address, in the direction the device selects.

All memory access goes through a word-addressed port with one read strobe, one write strobe and a read latency of one cycle. The request code is sampled only while the sequencer is idle. The device address, device data and qualifier lines are captured in that same cycle. The sequencer runs exactly one job and then returns to idle.

Top module: `dchan_seq`

## Requirements
- R1: While reset is applied, and in the first cycle after it, mem_rd, mem_wr, done, rd_valid, wc_ovf and sum_ovf are all low.
- R2: The request code is {dch_req, sc_req}. Code 00 starts nothing, whatever the qualifier lines show. Code 11 writes dev_wdata to dev_addr, with done in the first cycle after the sampling edge. Code 01 reads dev_addr and shows the word on dev_rdata with rd_valid and done in the second cycle. inc_req, add_req, mc_to_mem and addr_inh have no effect with codes 01 and 11.
- R3: With code 10 and neither inc_req nor add_req, the word at dev_addr is rewritten as its value plus one, modulo 2^DATA_W. The current-address word is at dev_addr plus one, modulo 2^ADDR_W.
- R4: wc_ovf is high for exactly one cycle, the word-count write-back cycle, when the incremented count is zero. Otherwise it stays low for the whole transfer.
- R5: When addr_inh is low, the current-address word is rewritten as its value plus one, and the data word moves at the low ADDR_W bits of the new value. When addr_inh is high, the current-address word is not written, and the data moves at the low ADDR_W bits of its stored value.
- R6: In a multi-cycle transfer with mc_to_mem high, dev_wdata is written, and done comes in the fifth cycle after the sampling edge. With mc_to_mem low, the data word is read and shown on dev_rdata with rd_valid and done in the sixth cycle.
- R7: With code 10 and inc_req high, the word at dev_addr becomes its value plus one, wrapping to zero, in a two-cycle job that never touches dev_addr plus one. wc_ovf stays low during this job, and inc_req wins over add_req.
- R8: With code 10, add_req high and inc_req low, the word at dev_addr becomes its sum with dev_wdata, modulo 2^DATA_W. sum_ovf pulses with done when both operands have the same sign bit and the sum's sign bit differs from it.
- R9: Requests and device inputs that change while a job runs have no effect. The word moved is the one captured at the sampling edge, and each job ends with a single done pulse followed by an idle cycle.
- R10: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge |
| dch_req | input | 1 | Channel request, upper bit of the request code |
| sc_req | input | 1 | Single-cycle request, lower bit of the request code |
| inc_req | input | 1 | With code 10: increment the word at dev_addr |
| add_req | input | 1 | With code 10: add dev_wdata to the word at dev_addr |
| mc_to_mem | input | 1 | Multi-cycle direction: 1 device to memory, 0 memory to device |
| addr_inh | input | 1 | Keep the current-address word unchanged |
| dev_addr | input | ADDR_W | Word-count address, or absolute address |
| dev_wdata | input | DATA_W | Word from the device |
| dev_rdata | output | DATA_W | Word to the device, valid with rd_valid |
| rd_valid | output | 1 | dev_rdata holds a word read from memory |
| done | output | 1 | Last cycle of the job |
| wc_ovf | output | 1 | Word count reached zero: last word |
| sum_ovf | output | 1 | Signed overflow in an add-to-memory job |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rd | output | 1 | Memory read strobe, data returned next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
The bench builds the sequencer with ADDR_W = 6 and DATA_W = 8, so a 64-word memory model covers the whole address space. With these sizes a word count at address 63 puts its current-address word at address 0. An 8-bit current address is cut down to 6 address bits, which lets the bench check the truncation. It also makes both positive and negative signed overflow easy to reach with small operands. The same sizes give a word count stepping from all ones to zero and a current address that wraps from 0xFF.

// File: rtl/dchan_pkg.sv
package dchan_pkg;

  // Job selected at the sampling edge
  typedef enum logic [2:0] {
    OP_NONE,
    OP_SIN,
    OP_SOUT,
    OP_MC,
    OP_INC,
    OP_ADD
  } op_e;

  // Sequencer states
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WC_RD,
    ST_WC_WB,
    ST_CA_RD,
    ST_CA_WB,
    ST_D_WR,
    ST_D_RD,
    ST_D_OUT,
    ST_M_RD,
    ST_M_WB
  } state_e;

endpackage

// File: rtl/dchan_decode.sv
module dchan_decode
  import dchan_pkg::*;
(
  input  logic dch_req,
  input  logic sc_req,
  input  logic inc_req,
  input  logic add_req,
  output op_e  op
);

  logic [1:0] code;
  assign code = {dch_req, sc_req};

  // 00 none, 01 single out, 10 multi-cycle, 11 single in
  always_comb begin
    op = OP_NONE;
    unique case (code)
      2'b00: op = OP_NONE;
      2'b01: op = OP_SOUT;
      2'b11: op = OP_SIN;
      2'b10: begin
        if (inc_req)      op = OP_INC;
        else if (add_req) op = OP_ADD;
        else              op = OP_MC;
      end
      default: op = OP_NONE;
    endcase
  end

endmodule

// File: rtl/dchan_ctrl.sv
module dchan_ctrl
  import dchan_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  op_e    op_req,
  input  logic   dir_in,
  output state_e state,
  output op_e    op_q,
  output logic   dir_q,
  output logic   launch
);

  state_e state_d;

  assign launch = (state == ST_IDLE) && (op_req != OP_NONE);

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: begin
        unique case (op_req)
          OP_SIN:         state_d = ST_D_WR;
          OP_SOUT:        state_d = ST_D_RD;
          OP_MC:          state_d = ST_WC_RD;
          OP_INC, OP_ADD: state_d = ST_M_RD;
          default:        state_d = ST_IDLE;
        endcase
      end
      ST_WC_RD: state_d = ST_WC_WB;
      ST_WC_WB: state_d = ST_CA_RD;
      ST_CA_RD: state_d = ST_CA_WB;
      ST_CA_WB: state_d = dir_q ? ST_D_WR : ST_D_RD;
      ST_D_RD:  state_d = ST_D_OUT;
      ST_M_RD:  state_d = ST_M_WB;
      ST_D_WR, ST_D_OUT, ST_M_WB: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      op_q  <= OP_NONE;
      dir_q <= 1'b0;
    end else begin
      state <= state_d;
      if (launch) begin
        op_q  <= op_req;
        dir_q <= dir_in;
      end
    end
  end

  // R9: job kind and direction frozen while a job runs
  assert_op_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> ($stable(op_q) && $stable(dir_q)));

endmodule

// File: rtl/dchan_dpath.sv
module dchan_dpath
  import dchan_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  state_e            state,
  input  op_e               op_q,
  input  logic              launch,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [DATA_W-1:0] dev_wdata,
  input  logic              addr_inh,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] dev_rdata,
  output logic              rd_valid,
  output logic              done,
  output logic              wc_ovf,
  output logic              sum_ovf
);

  localparam int SGN = DATA_W - 1;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] daddr_q, daddr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              inh_q, inh_d;
  logic              daddr_en;

  logic [ADDR_W-1:0] ca_addr;
  logic [ADDR_W-1:0] xfer_addr;
  logic [DATA_W-1:0] rd_plus1;
  logic [DATA_W-1:0] rd_sum;

  assign ca_addr   = base_q + ADDR_W'(1);
  assign rd_plus1  = mem_rdata + DATA_W'(1);
  assign rd_sum    = mem_rdata + data_q;
  assign xfer_addr = (op_q == OP_MC) ? daddr_q : base_q;

  // capture stage
  always_comb begin
    base_d   = base_q;
    data_d   = data_q;
    inh_d    = inh_q;
    daddr_d  = daddr_q;
    daddr_en = (state == ST_CA_WB);
    if (launch) begin
      base_d = dev_addr;
      data_d = dev_wdata;
      inh_d  = addr_inh;
    end
    if (daddr_en) begin
      daddr_d = inh_q ? mem_rdata[ADDR_W-1:0] : rd_plus1[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      data_q  <= '0;
      inh_q   <= 1'b0;
      daddr_q <= '0;
    end else begin
      if (launch) begin
        base_q <= base_d;
        data_q <= data_d;
        inh_q  <= inh_d;
      end
      if (daddr_en) daddr_q <= daddr_d;
    end
  end

  // memory port and device-side outputs
  always_comb begin
    mem_addr  = base_q;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_wdata = '0;
    rd_valid  = 1'b0;
    done      = 1'b0;
    wc_ovf    = 1'b0;
    sum_ovf   = 1'b0;
    unique case (state)
      ST_WC_RD: mem_rd = 1'b1;
      ST_WC_WB: begin
        mem_wr    = 1'b1;
        mem_wdata = rd_plus1;
        wc_ovf    = (rd_plus1 == '0);
      end
      ST_CA_RD: begin
        mem_addr = ca_addr;
        mem_rd   = 1'b1;
      end
      ST_CA_WB: begin
        mem_addr  = ca_addr;
        mem_wr    = !inh_q;
        mem_wdata = rd_plus1;
      end
      ST_D_WR: begin
        mem_addr  = xfer_addr;
        mem_wr    = 1'b1;
        mem_wdata = data_q;
        done      = 1'b1;
      end
      ST_D_RD: begin
        mem_addr = xfer_addr;
        mem_rd   = 1'b1;
      end
      ST_D_OUT: begin
        rd_valid = 1'b1;
        done     = 1'b1;
      end
      ST_M_RD: mem_rd = 1'b1;
      ST_M_WB: begin
        mem_wr = 1'b1;
        done   = 1'b1;
        if (op_q == OP_ADD) begin
          mem_wdata = rd_sum;
          sum_ovf   = (mem_rdata[SGN] == data_q[SGN]) && (rd_sum[SGN] != data_q[SGN]);
        end else begin
          mem_wdata = rd_plus1;
        end
      end
      default: ;
    endcase
  end

  assign dev_rdata = rd_valid ? mem_rdata : '0;

  // R10: one strobe at a time
  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R4: overflow only while a zero count is written back
  assert_wc_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wc_ovf |-> (mem_wr && mem_wdata == '0 && mem_addr == base_q));

  // R3: the current-address read follows the word-count address
  assert_ca_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CA_RD) |-> (mem_rd && mem_addr == $past(mem_addr) + ADDR_W'(1)));

  // R6: a word goes to the device only after a memory read
  assert_rvalid_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(mem_rd));

  // R8: sum overflow only with the write of the sum
  assert_sum_ovf_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sum_ovf |-> (mem_wr && done));

  // R9: captured device word held through the job
  assert_data_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(data_q));

endmodule

// File: rtl/dchan_seq.sv
module dchan_seq
  import dchan_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dch_req,
  input  logic              sc_req,
  input  logic              inc_req,
  input  logic              add_req,
  input  logic              mc_to_mem,
  input  logic              addr_inh,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [DATA_W-1:0] dev_wdata,
  output logic [DATA_W-1:0] dev_rdata,
  output logic              rd_valid,
  output logic              done,
  output logic              wc_ovf,
  output logic              sum_ovf,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic [1:0] rst_pipe;
  logic       rst_i_n;
  op_e        op_req;
  op_e        op_q;
  state_e     state;
  logic       dir_q;
  logic       launch;

  // asynchronous assert, clocked release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  dchan_decode u_decode (
    .dch_req (dch_req),
    .sc_req  (sc_req),
    .inc_req (inc_req),
    .add_req (add_req),
    .op      (op_req)
  );

  dchan_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .op_req (op_req),
    .dir_in (mc_to_mem),
    .state  (state),
    .op_q   (op_q),
    .dir_q  (dir_q),
    .launch (launch)
  );

  dchan_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .state     (state),
    .op_q      (op_q),
    .launch    (launch),
    .dev_addr  (dev_addr),
    .dev_wdata (dev_wdata),
    .addr_inh  (addr_inh),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .dev_rdata (dev_rdata),
    .rd_valid  (rd_valid),
    .done      (done),
    .wc_ovf    (wc_ovf),
    .sum_ovf   (sum_ovf)
  );

  // R9: every job is followed by a quiet idle cycle
  assert_done_then_idle_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> (!mem_rd && !mem_wr && !done));

  // R1: nothing moves in the cycle the internal reset lifts
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(rst_i_n) |-> (!mem_rd && !mem_wr && !done));

endmodule

// File: tb/tb_dchan_seq.sv
`timescale 1ns/1ps
module tb_dchan_seq;

  localparam int AW = 6;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          dch_req, sc_req, inc_req, add_req, mc_to_mem, addr_inh;
  logic [AW-1:0] dev_addr;
  logic [DW-1:0] dev_wdata;
  logic [DW-1:0] dev_rdata;
  logic          rd_valid, done, wc_ovf, sum_ovf;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  logic [DW-1:0] mem [64];
  logic          pl_en;
  logic [AW-1:0] pl_a;
  logic [DW-1:0] pl_d;

  int n_chk  = 0;
  int n_fail = 0;
  int both_strobes = 0;
  int cyc_total = 0;

  always #4 clk = ~clk;

  dchan_seq #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .dch_req(dch_req), .sc_req(sc_req),
    .inc_req(inc_req), .add_req(add_req), .mc_to_mem(mc_to_mem), .addr_inh(addr_inh),
    .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
    .rd_valid(rd_valid), .done(done), .wc_ovf(wc_ovf), .sum_ovf(sum_ovf),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model, one-cycle read latency
  always @(posedge clk) begin
    if (pl_en)       mem[pl_a] <= pl_d;
    else if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) if (rst_n && mem_rd && mem_wr) both_strobes++;

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc_total);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  typedef struct packed {
    logic [1:0]    code;
    logic          to_mem, inh, inc, add;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    logic [AW-1:0] tgt;
    logic [DW-1:0] m0, m1, m2;
    logic [3:0]    cyc;
    logic [DW-1:0] e0, e1, e2, erd;
    logic          ewc, eadd;
  } vec_t;

  // code,to_mem,inh,inc,add, addr,wd,tgt, m0,m1,m2, cyc, e0,e1,e2,erd, ewc,eadd
  localparam vec_t VECS [16] = '{
    '{2'd3,1'b0,1'b0,1'b0,1'b0, 6'h10,8'hA5,6'h30, 8'h00,8'h33,8'h77, 4'd1, 8'hA5,8'h33,8'h77,8'h00, 1'b0,1'b0},
    '{2'd1,1'b0,1'b0,1'b0,1'b0, 6'h12,8'h00,6'h30, 8'h5C,8'h11,8'h77, 4'd2, 8'h5C,8'h11,8'h77,8'h5C, 1'b0,1'b0},
    '{2'd2,1'b1,1'b0,1'b0,1'b0, 6'h14,8'h9C,6'h31, 8'hFD,8'h30,8'h00, 4'd5, 8'hFE,8'h31,8'h9C,8'h00, 1'b0,1'b0},
    '{2'd2,1'b0,1'b0,1'b0,1'b0, 6'h16,8'h00,6'h30, 8'hFF,8'h2F,8'h6E, 4'd6, 8'h00,8'h30,8'h6E,8'h6E, 1'b1,1'b0},
    '{2'd2,1'b1,1'b1,1'b0,1'b0, 6'h18,8'h42,6'h35, 8'hF0,8'h35,8'h00, 4'd5, 8'hF1,8'h35,8'h42,8'h00, 1'b0,1'b0},
    '{2'd2,1'b0,1'b1,1'b0,1'b0, 6'h1A,8'h00,6'h38, 8'hFE,8'h38,8'h19, 4'd6, 8'hFF,8'h38,8'h19,8'h19, 1'b0,1'b0},
    '{2'd2,1'b1,1'b0,1'b0,1'b0, 6'h3F,8'h3B,6'h06, 8'h80,8'hC5,8'h00, 4'd5, 8'h81,8'hC6,8'h3B,8'h00, 1'b0,1'b0},
    '{2'd2,1'b0,1'b0,1'b0,1'b0, 6'h1C,8'h00,6'h00, 8'h01,8'hFF,8'h55, 4'd6, 8'h02,8'h00,8'h55,8'h55, 1'b0,1'b0},
    '{2'd2,1'b0,1'b0,1'b1,1'b0, 6'h1E,8'h00,6'h30, 8'h7F,8'h44,8'h77, 4'd2, 8'h80,8'h44,8'h77,8'h00, 1'b0,1'b0},
    '{2'd2,1'b0,1'b0,1'b1,1'b0, 6'h20,8'h00,6'h30, 8'hFF,8'h44,8'h77, 4'd2, 8'h00,8'h44,8'h77,8'h00, 1'b0,1'b0},
    '{2'd2,1'b0,1'b0,1'b0,1'b1, 6'h22,8'h20,6'h30, 8'h70,8'h44,8'h77, 4'd2, 8'h90,8'h44,8'h77,8'h00, 1'b0,1'b1},
    '{2'd2,1'b0,1'b0,1'b0,1'b1, 6'h24,8'hF0,6'h30, 8'h70,8'h44,8'h77, 4'd2, 8'h60,8'h44,8'h77,8'h00, 1'b0,1'b0},
    '{2'd2,1'b0,1'b0,1'b0,1'b1, 6'h26,8'hFF,6'h30, 8'h80,8'h44,8'h77, 4'd2, 8'h7F,8'h44,8'h77,8'h00, 1'b0,1'b1},
    '{2'd2,1'b0,1'b0,1'b1,1'b1, 6'h28,8'h05,6'h30, 8'h10,8'h44,8'h77, 4'd2, 8'h11,8'h44,8'h77,8'h00, 1'b0,1'b0},
    '{2'd1,1'b1,1'b0,1'b1,1'b1, 6'h2A,8'h99,6'h30, 8'h3C,8'h44,8'h77, 4'd2, 8'h3C,8'h44,8'h77,8'h3C, 1'b0,1'b0},
    '{2'd3,1'b0,1'b1,1'b1,1'b0, 6'h2C,8'h81,6'h30, 8'h00,8'h44,8'h77, 4'd1, 8'h81,8'h44,8'h77,8'h00, 1'b0,1'b0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    dch_req = 1'b0; sc_req = 1'b0; inc_req = 1'b0; add_req = 1'b0;
    mc_to_mem = 1'b0; addr_inh = 1'b0;
  endtask

  task automatic preload(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    pl_en = 1'b1; pl_a = a; pl_d = d;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    string tag;
    string tca;
    string tdat;
    int    n;
    logic  seen_wc, seen_add;
    logic [DW-1:0] rd;
    if (v.code == 2'd2 && v.inc)      tag = "R7";
    else if (v.code == 2'd2 && v.add) tag = "R8";
    else if (v.code == 2'd2)          tag = "R3";
    else                              tag = "R2";
    tca  = (tag == "R3") ? "R5" : tag;
    tdat = (tag == "R3") ? "R6" : tag;
    preload(v.addr, v.m0);
    preload(v.addr + AW'(1), v.m1);
    preload(v.tgt, v.m2);
    {dch_req, sc_req} = v.code;
    mc_to_mem = v.to_mem; addr_inh = v.inh; inc_req = v.inc; add_req = v.add;
    dev_addr = v.addr; dev_wdata = v.wd;
    seen_wc = 1'b0; seen_add = 1'b0; rd = '0; n = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == 1) idle_inputs();
      n = k;
      if (wc_ovf)   seen_wc = 1'b1;
      if (sum_ovf)  seen_add = 1'b1;
      if (rd_valid) rd = dev_rdata;
      if (done) break;
    end
    @(negedge clk);
    chk(tdat, $sformatf("vec %0d done cycle", idx), n, int'(v.cyc));
    chk(tag,  $sformatf("vec %0d word at addr", idx), int'(mem[v.addr]), int'(v.e0));
    chk(tca,  $sformatf("vec %0d word at addr+1", idx), int'(mem[v.addr + AW'(1)]), int'(v.e1));
    chk(tdat, $sformatf("vec %0d data location", idx), int'(mem[v.tgt]), int'(v.e2));
    chk(tdat, $sformatf("vec %0d dev_rdata", idx), int'(rd), int'(v.erd));
    chk("R4", $sformatf("vec %0d wc_ovf", idx), int'(seen_wc), int'(v.ewc));
    chk("R8", $sformatf("vec %0d sum_ovf", idx), int'(seen_add), int'(v.eadd));
  endtask

  initial begin
    int strobes;
    int dones;
    pl_en = 1'b0; pl_a = '0; pl_d = '0;
    idle_inputs();
    dev_addr = '0; dev_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1", "mem_rd in reset", int'(mem_rd), 0);
    chk("R1", "mem_wr in reset", int'(mem_wr), 0);
    chk("R1", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    // R1: first cycle after internal release
    chk("R1", "strobes after reset", int'(mem_rd | mem_wr), 0);
    chk("R1", "rd_valid/wc_ovf/sum_ovf after reset", int'(rd_valid | wc_ovf | sum_ovf), 0);

    foreach (VECS[i]) run_vec(VECS[i], i);

    // R2: code 00 with every qualifier set starts nothing
    inc_req = 1'b1; add_req = 1'b1; mc_to_mem = 1'b1; addr_inh = 1'b1;
    dev_addr = 6'h05; dev_wdata = 8'hEE;
    strobes = 0; dones = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (mem_rd || mem_wr) strobes++;
      if (done) dones++;
    end
    idle_inputs();
    chk("R2", "strobes with code 00", strobes, 0);
    chk("R2", "done with code 00", dones, 0);

    // R9: a request raised mid-job is ignored, captured data is used
    preload(6'h08, 8'hFE);
    preload(6'h09, 8'h20);
    preload(6'h21, 8'h00);
    preload(6'h3A, 8'h66);
    dch_req = 1'b1; mc_to_mem = 1'b1; dev_addr = 6'h08; dev_wdata = 8'h5A;
    dones = 0;
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      if (k == 1) idle_inputs();
      if (k == 2) begin
        dch_req = 1'b1; sc_req = 1'b1; dev_addr = 6'h3A; dev_wdata = 8'hC3;
      end
      if (k == 3) idle_inputs();
      if (done) dones++;
    end
    chk("R9", "done pulses for one job", dones, 1);
    chk("R9", "captured word written", int'(mem[6'h21]), 8'h5A);
    chk("R9", "mid-job request location", int'(mem[6'h3A]), 8'h66);

    // R1: reset in the middle of a multi-cycle job
    preload(6'h0C, 8'h10);
    preload(6'h0D, 8'h2E);
    dch_req = 1'b1; dev_addr = 6'h0C;
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "strobes after mid-job reset", int'(mem_rd | mem_wr), 0);
    chk("R1", "done after mid-job reset", int'(done), 0);
    @(negedge clk);
    rst_n = 1'b1;
    strobes = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (mem_rd || mem_wr || done) strobes++;
    end
    chk("R1", "quiet after mid-job reset", strobes, 0);

    // R10: never both strobes at once
    chk("R10", "cycles with read and write", both_strobes, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule